// File: doc/BRIEF.md
# Interrupt Acknowledge Pulse Expander

This block sits between a bus bridge and an on-chip pair of cascaded 8259-style interrupt controllers. The bridge delivers an interrupt acknowledge as a single one-cycle request. The controllers need two separate acknowledge pulses: the first freezes priority and identifies the source, and the second returns the vector. The block produces those two pulses from the one request.

While the sequence runs, the block holds a wait output high so that the requester stalls. Each pulse is PULSE_W clocks wide. The two pulses are separated by GAP clocks, and that gap is the only spacing between them. When the first pulse ends, the block emits a one-cycle strobe that tells the master controller to drive the cascade code.

The block samples the vector returned on the second pulse and presents it with a one-cycle done strobe. It drops wait in that same cycle and then returns to idle. The acknowledge and cascade outputs run only to the neighbouring controllers and never reach the chip's pads.

Top module: `ackx_expander`

## Requirements
- R1: Each accepted request produces exactly two rising edges on `ctl_ack_o`, and each pulse stays high for exactly PULSE_W clocks. With the request sampled at clock edge E0, the first pulse is high in cycles 1..PULSE_W after E0.
- R2: `ctl_ack_o` stays low for exactly GAP clocks between the two pulses. The second pulse is high in cycles PULSE_W+GAP+1 .. 2*PULSE_W+GAP.
- R3: `wait_o` rises in cycle 1 after the accepting edge and stays high through the last cycle of the second pulse. It is high whenever `ctl_ack_o` or `casc_stb_o` is high.
- R4: `done_o` is high for exactly one cycle, cycle 2*PULSE_W+GAP+1, and `wait_o` is low in that cycle.
- R5: `vec_o` takes the value that `ctl_vec_i` has in the last cycle of the second pulse. Values on `ctl_vec_i` in any other cycle are not taken. `vec_o` is valid while `done_o` is high and keeps its value until the next `done_o`.
- R6: `casc_stb_o` is high for exactly one cycle, cycle PULSE_W+1: the first cycle after the first pulse falls.
- R7: `req_i` is ignored while `wait_o` or `done_o` is high, and the running sequence keeps its timing. A request in the first idle cycle after `done_o` is accepted.
- R8: With `rst` high at a clock edge, the block returns to idle. After that edge `wait_o`, `ctl_ack_o`, `casc_stb_o` and `done_o` are low and `vec_o` is zero.
- R9: While idle and without a request, `ctl_ack_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Single-cycle acknowledge request from the bridge |
| ctl_vec_i | input | VEC_W | Vector driven by the controller pair |
| ctl_ack_o | output | 1 | Acknowledge pulse to the controller pair (on-chip only) |
| casc_stb_o | output | 1 | Cascade-code strobe at the end of the first pulse (on-chip only) |
| wait_o | output | 1 | Stall to the requester while the sequence runs |
| done_o | output | 1 | One-cycle strobe marking `vec_o` valid |
| vec_o | output | VEC_W | Captured interrupt vector |

## Verification
A corrupted phase or count register shows up at the ports within one sequence. It appears as a pulse that is too long or too short, a third pulse, a misplaced cascade strobe, or `done_o` arriving in the wrong cycle. The bench compares every output in every cycle against a cycle index, so the first wrong cycle is reported. A capture taken in the wrong cycle is exposed because the vector input carries the expected value only in the last cycle of the second pulse and the complement at all other times. Requests held high across a whole sequence show that a restart or a stretched sequence is detected within the same sequence.

// File: rtl/ackx_pkg.sv
package ackx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ACK1  = 3'd1,
        PH_SPACE = 3'd2,
        PH_ACK2  = 3'd3,
        PH_DONE  = 3'd4
    } ack_phase_e;

    typedef struct packed {
        logic ack;
        logic busy;
        logic done;
        logic cap;
    } seq_ctl_t;

    function automatic int unsigned phase_len(ack_phase_e ph, int unsigned pw, int unsigned gw);
        case (ph)
            PH_ACK1, PH_ACK2: return pw;
            PH_SPACE:         return gw;
            default:          return 1;
        endcase
    endfunction

    function automatic ack_phase_e phase_next(ack_phase_e ph, logic req, logic last);
        case (ph)
            PH_IDLE:  return req  ? PH_ACK1  : PH_IDLE;
            PH_ACK1:  return last ? PH_SPACE : PH_ACK1;
            PH_SPACE: return last ? PH_ACK2  : PH_SPACE;
            PH_ACK2:  return last ? PH_DONE  : PH_ACK2;
            default:  return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/ackx_timer.sv
module ackx_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/ackx_seq.sv
module ackx_seq
    import ackx_pkg::*;
#(
    parameter int PULSE_W = 2,
    parameter int GAP     = 1,
    parameter int CW      = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          last,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          casc,
    output seq_ctl_t      ctl
);
    ack_phase_e phase_q, phase_d;
    logic       casc_q;

    always_comb begin
        phase_d  = phase_next(phase_q, req, last);
        load     = (phase_d != phase_q);
        load_val = CW'(phase_len(phase_d, PULSE_W, GAP) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            casc_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            casc_q  <= (phase_q == PH_ACK1) && last;
        end
    end

    always_comb begin
        ctl.ack  = (phase_q == PH_ACK1) || (phase_q == PH_ACK2);
        ctl.busy = (phase_q == PH_ACK1) || (phase_q == PH_SPACE) || (phase_q == PH_ACK2);
        ctl.done = (phase_q == PH_DONE);
        ctl.cap  = (phase_q == PH_ACK2) && last;
    end

    assign casc = casc_q;
endmodule

// File: rtl/ackx_vec_latch.sv
module ackx_vec_latch #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [VEC_W-1:0] din,
    output logic [VEC_W-1:0] dout
);
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (cap) begin
            vec_q <= din;
        end
    end

    assign dout = vec_q;
endmodule

// File: rtl/ackx_expander.sv
module ackx_expander
    import ackx_pkg::*;
#(
    parameter int PULSE_W = 2,
    parameter int GAP     = 1,
    parameter int VEC_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [VEC_W-1:0] ctl_vec_i,
    output logic             ctl_ack_o,
    output logic             casc_stb_o,
    output logic             wait_o,
    output logic             done_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam int SPAN = (PULSE_W > GAP) ? PULSE_W : GAP;
    localparam int CW   = $clog2(SPAN + 1);

    logic          load;
    logic [CW-1:0] load_val;
    logic          last;
    logic          casc;
    seq_ctl_t      ctl;

    ackx_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    ackx_seq #(.PULSE_W(PULSE_W), .GAP(GAP), .CW(CW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req_i),
        .last     (last),
        .load     (load),
        .load_val (load_val),
        .casc     (casc),
        .ctl      (ctl)
    );

    ackx_vec_latch #(.VEC_W(VEC_W)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .cap  (ctl.cap),
        .din  (ctl_vec_i),
        .dout (vec_o)
    );

    assign ctl_ack_o  = ctl.ack;
    assign casc_stb_o = casc;
    assign wait_o     = ctl.busy;
    assign done_o     = ctl.done;
endmodule

// File: rtl/ackx_chk.sv
module ackx_chk #(
    parameter int PULSE_W = 2,
    parameter int GAP     = 1,
    parameter int VEC_W   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_i,
    input logic [VEC_W-1:0] ctl_vec_i,
    input logic             ctl_ack_o,
    input logic             casc_stb_o,
    input logic             wait_o,
    input logic             done_o,
    input logic [VEC_W-1:0] vec_o
);
    logic       ack_q;
    logic       rst_q;
    logic [7:0] rises;
    logic [7:0] hi_len;
    logic [7:0] lo_len;
    logic       idle;

    assign idle = !wait_o && !done_o;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            ack_q  <= 1'b0;
            rises  <= '0;
            hi_len <= '0;
            lo_len <= '0;
        end else begin
            ack_q  <= ctl_ack_o;
            hi_len <= ctl_ack_o ? hi_len + 1'b1 : 8'd0;
            lo_len <= (wait_o && !ctl_ack_o) ? lo_len + 1'b1 : 8'd0;
            if (idle && req_i) begin
                rises <= '0;
            end else if (ctl_ack_o && !ack_q) begin
                rises <= rises + 1'b1;
            end
        end
    end

    assert_two_pulses_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (rises == 8'd2));

    assert_pulse_width_R1: assert property (@(posedge clk) disable iff (rst)
        (ack_q && !ctl_ack_o) |-> (hi_len == 8'(PULSE_W)));

    assert_gap_len_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_ack_o && !ack_q && rises == 8'd1) |-> (lo_len == 8'(GAP)));

    assert_wait_cover_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_ack_o || casc_stb_o) |-> wait_o);

    assert_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (idle && req_i) |=> (wait_o && ctl_ack_o));

    assert_done_unwait_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !wait_o);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !wait_o));

    assert_vec_capture_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (vec_o == $past(ctl_vec_i) && $past(ctl_ack_o)));

    assert_vec_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !done_o |=> (done_o || $stable(vec_o)));

    assert_casc_edge_R6: assert property (@(posedge clk) disable iff (rst)
        casc_stb_o |-> (ack_q && !ctl_ack_o && rises == 8'd1));

    assert_busy_keep_R7: assert property (@(posedge clk) disable iff (rst)
        wait_o |=> (wait_o || done_o));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (idle && !req_i) |=> !ctl_ack_o);

    always_ff @(posedge clk) begin
        if (rst_q && !rst) begin
            assert_reset_idle_R8: assert (!wait_o && !ctl_ack_o && !casc_stb_o && !done_o);
        end
    end
endmodule

bind ackx_expander ackx_chk #(.PULSE_W(PULSE_W), .GAP(GAP), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .ctl_vec_i  (ctl_vec_i),
    .ctl_ack_o  (ctl_ack_o),
    .casc_stb_o (casc_stb_o),
    .wait_o     (wait_o),
    .done_o     (done_o),
    .vec_o      (vec_o)
);

// File: tb/ackx_expander_bench.sv
module ackx_expander_bench;
    localparam int W  = 2;
    localparam int G  = 1;
    localparam int VW = 8;
    localparam int L  = 2 * W + G + 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_i;
    logic [VW-1:0] ctl_vec_i;
    logic          ctl_ack_o, casc_stb_o, wait_o, done_o;
    logic [VW-1:0] vec_o;

    int total = 0;
    int bad   = 0;
    logic [VW-1:0] prev_v;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    ackx_expander #(.PULSE_W(W), .GAP(G), .VEC_W(VW)) u_ackx_expander (
        .clk(clk), .rst(rst), .req_i(req_i), .ctl_vec_i(ctl_vec_i),
        .ctl_ack_o(ctl_ack_o), .casc_stb_o(casc_stb_o), .wait_o(wait_o),
        .done_o(done_o), .vec_o(vec_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a negedge in an idle cycle: request goes out this cycle (cycle 0).
    task automatic run_seq(input logic [VW-1:0] v, input bit busy_req);
        req_i     = 1'b1;
        ctl_vec_i = ~v;
        for (int k = 1; k <= L; k++) begin
            @(negedge clk);
            chk("R1 R2 ack pulse pattern", int'(ctl_ack_o),
                int'((k >= 1 && k <= W) || (k >= W + G + 1 && k <= 2 * W + G)));
            chk("R6 cascade strobe", int'(casc_stb_o), int'(k == W + 1));
            chk(busy_req ? "R3 R7 wait with repeated requests" : "R3 wait",
                int'(wait_o), int'(k >= 1 && k <= 2 * W + G));
            chk("R4 done strobe", int'(done_o), int'(k == 2 * W + G + 1));
            chk("R5 vector", int'(vec_o), int'((k >= 2 * W + G + 1) ? v : prev_v));
            req_i     = busy_req && (k <= 2 * W + G + 1);
            ctl_vec_i = (k == 2 * W + G) ? v : ~v;
        end
        prev_v = v;
    endtask

    task automatic idle_cycles(input int n);
        req_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9 idle ack low", int'(ctl_ack_o), 0);
            chk("R9 idle wait low", int'(wait_o), 0);
            chk("R5 vector held while idle", int'(vec_o), int'(prev_v));
        end
    endtask

    initial begin
        rst = 1'b1; req_i = 1'b0; ctl_vec_i = '0; prev_v = '0;
        repeat (3) @(negedge clk);
        chk("R8 reset wait", int'(wait_o), 0);
        chk("R8 reset ack", int'(ctl_ack_o), 0);
        chk("R8 reset done", int'(done_o), 0);
        chk("R8 reset casc", int'(casc_stb_o), 0);
        chk("R8 reset vector", int'(vec_o), 0);
        rst = 1'b0;
        idle_cycles(2);

        for (int v = 0; v < 256; v++) begin
            run_seq(VW'(v), (v % 3) == 0);
            if (v % 5 == 0) idle_cycles(2);
        end

        // R8: reset in the middle of a sequence
        req_i = 1'b1; ctl_vec_i = 8'h5A;
        @(negedge clk); req_i = 1'b0;
        @(negedge clk);
        chk("R8 mid-sequence busy before reset", int'(wait_o), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 mid reset wait", int'(wait_o), 0);
        chk("R8 mid reset ack", int'(ctl_ack_o), 0);
        chk("R8 mid reset casc", int'(casc_stb_o), 0);
        chk("R8 mid reset vector", int'(vec_o), 0);
        rst = 1'b0; prev_v = '0;
        idle_cycles(1);
        run_seq(8'h3C, 1'b0);
        run_seq(8'hC3, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule